// File: doc/BRIEF.md
# SPI Flash Transaction Decoder

This block watches the lines of an SPI flash bus without driving them and turns each chip-select frame into a small set of events. The first byte of a frame is the command opcode. The decoder looks this opcode up in an eight-entry table. The matching entry sets how many address bytes follow, how many dummy sampling edges to wait out, how many data lanes the payload uses and whether the host or the device drives the payload. Once the dummy edges have passed, the block raises a header event. It then sends out every complete payload byte as a one-cycle strobe, and it signals the end of the frame with an end event that carries a dropped flag.

The SPI inputs are sampled on the system clock, which must run well above the serial clock. Both the lines the host drives and the lines the device drives are observed, on separate 4-bit inputs. Software-style configuration of the opcode table goes through a simple write port (index, valid, opcode and entry fields). The clock mode is selected with static polarity and phase inputs.

Top module: `spi_flash_decoder`

## Requirements
- R1: The opcode is the first 8 sampled bits after chip select falls, most significant bit first, taken from host line 0 only, and is reported on hdrOpcode.
- R2: The table lookup picks the lowest-index valid entry whose opcode matches. Its fields are address length (4 bytes when tblAddr4 is 1, else 3), write flag, lane code (0 = one lane, 1 = two lanes, 2 = four lanes; code 3 is stored and reported as 0) and dummy edge count. An entry written with tblValid low never matches.
- R3: An opcode that matches no valid entry yields 3 address bytes, 0 dummy edges, one lane and read direction.
- R4: The address bytes follow the opcode, most significant byte first and bit first, on host line 0. They are reported on hdrAddr right-aligned, with the upper byte zero for a 3-byte address.
- R5: After the address, the number of sampling edges given by the dummy count carry no data.
- R6: hdrValid pulses for exactly one cycle per frame, after the last dummy edge (or the last address byte when the count is 0), and before any dataValid of that frame.
- R7: Payload bits come from the host lines when the write flag is set and from the device lines otherwise. One lane uses host line 0 or device line 1. Two lanes use lines 1:0, with line 1 the more significant bit. Four lanes use lines 3:0, with line 3 the most significant bit. Bytes are most significant first.
- R8: The payload runs until chip select rises. Each completed byte gives one dataValid pulse, and a partly received byte at the end is discarded.
- R9: A rise of chip select in a started frame gives one endValid pulse. endDropped is 1 exactly when fewer than 8 opcode bits arrived, and such a frame gives no header.
- R10: Bits are sampled on rising serial-clock edges when cpol equals cpha, and on falling edges otherwise. In modes with cpha = 1, the leading edge after chip select falls carries no bit.
- R11: During and immediately after reset, hdrValid, dataValid and endValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase |
| spiCsN | input | 1 | Observed chip select, active low |
| spiSck | input | 1 | Observed serial clock |
| hostIo | input | 4 | Data lines as driven by the host |
| devIo | input | 4 | Data lines as driven by the device |
| tblWe | input | 1 | Table write strobe |
| tblIdx | input | 3 | Table entry index |
| tblValid | input | 1 | Entry valid bit written |
| tblOpcode | input | 8 | Entry opcode |
| tblAddr4 | input | 1 | Entry uses 4 address bytes |
| tblWrite | input | 1 | Entry payload is host driven |
| tblLanes | input | 2 | Entry lane code |
| tblDummy | input | 5 | Entry dummy edge count |
| hdrValid | output | 1 | Header event strobe |
| hdrOpcode | output | 8 | Captured opcode |
| hdrAddr | output | 32 | Captured address |
| hdrWrite | output | 1 | Payload direction of this frame |
| hdrLanes | output | 2 | Lane code of this frame |
| hdrDummy | output | 5 | Dummy edge count of this frame |
| dataValid | output | 1 | Payload byte strobe |
| dataByte | output | 8 | Payload byte |
| endValid | output | 1 | End-of-frame strobe |
| endDropped | output | 1 | Frame ended before a full opcode |

## Verification
The bench goes after frames cut short inside the opcode and inside the address. A decoder that misjudged these would report a header, or would set the dropped flag on the wrong frame. Duplicate opcodes in the table and an entry written invalid test the lookup priority; a wrong priority shows up as the wrong lane code or payload values. Every clock mode is run with junk on the lines the frame does not use, so a counted leading edge, a wrong lane order or the wrong data source all corrupt the bytes received. Trailing partial bytes and a dummy count of zero test whether a stray byte is emitted or the header is placed wrongly.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;
  parameter int DUMMY_W = 5;
  parameter int MAX_ADDR_BYTES = 4;
  parameter int ADDR_W = 8 * MAX_ADDR_BYTES;

  typedef enum logic [1:0] {
    LANE1 = 2'd0,
    LANE2 = 2'd1,
    LANE4 = 2'd2,
    LANE_RSVD = 2'd3
  } lanes_e;

  typedef struct packed {
    logic addr4;
    logic isWrite;
    lanes_e lanes;
    logic [DUMMY_W-1:0] dummy;
  } opCfg_t;

  typedef struct packed {
    logic shiftEn;
    lanes_e lanes;
    logic useDev;
    logic clrBits;
    logic loadOp;
    logic pushAddr;
    logic clrAddr;
    logic dataEn;
  } dpStrobe_t;

  function automatic logic [3:0] laneStep(lanes_e l);
    case (l)
      LANE2: return 4'd2;
      LANE4: return 4'd4;
      default: return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/spi_dec_optable.sv
module spi_dec_optable
  import spi_dec_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic wrValid,
  input  logic [7:0] wrOpcode,
  input  opCfg_t wrCfg,
  input  logic [7:0] lookOpcode,
  output opCfg_t lookCfg
);
  logic [ENTRIES-1:0] entValid;
  logic [7:0] entOpcode [ENTRIES];
  opCfg_t entCfg [ENTRIES];
  opCfg_t wrNorm;

  always_comb begin
    wrNorm = wrCfg;
    if (wrCfg.lanes == LANE_RSVD) wrNorm.lanes = LANE1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entOpcode[g] <= '0;
        entCfg[g] <= '0;
      end else if (wrEn && wrIdx == IDX_W'(g)) begin
        entValid[g] <= wrValid;
        entOpcode[g] <= wrOpcode;
        entCfg[g] <= wrNorm;
      end
    end
  end

  always_comb begin
    lookCfg = '{addr4: 1'b0, isWrite: 1'b0, lanes: LANE1, dummy: '0};
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (entValid[i] && entOpcode[i] == lookOpcode) lookCfg = entCfg[i];
    end
  end
endmodule

// File: rtl/spi_dec_datapath.sv
module spi_dec_datapath
  import spi_dec_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic cpol,
  input  logic cpha,
  input  logic spiCsN,
  input  logic spiSck,
  input  logic [3:0] hostIo,
  input  logic [3:0] devIo,
  input  dpStrobe_t strobe,
  output logic sampleEdge,
  output logic csFall,
  output logic csRise,
  output logic [3:0] bitCnt,
  output logic [7:0] opcode,
  output logic [ADDR_W-1:0] address,
  output logic dataValid,
  output logic [7:0] dataByte
);
  logic csQ, csPrev, sckQ, sckPrev;
  logic [3:0] hostQ, devQ;
  logic [7:0] shReg, nextByte;
  logic [3:0] srcBits, stepSum;
  logic byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b1;
      csPrev <= 1'b1;
      sckQ <= 1'b0;
      sckPrev <= 1'b0;
      hostQ <= '0;
      devQ <= '0;
    end else begin
      csQ <= spiCsN;
      csPrev <= csQ;
      sckQ <= spiSck;
      sckPrev <= sckQ;
      hostQ <= hostIo;
      devQ <= devIo;
    end
  end

  assign csFall = csPrev && !csQ;
  assign csRise = !csPrev && csQ;
  assign sampleEdge = !csQ && (sckQ != sckPrev) && (sckQ == !(cpol ^ cpha));

  assign srcBits = strobe.useDev ? devQ : hostQ;
  assign stepSum = bitCnt + laneStep(strobe.lanes);
  assign byteDone = strobe.shiftEn && stepSum == 4'd8;

  always_comb begin
    case (strobe.lanes)
      LANE2: nextByte = {shReg[5:0], srcBits[1:0]};
      LANE4: nextByte = {shReg[3:0], srcBits[3:0]};
      default: nextByte = {shReg[6:0], strobe.useDev ? srcBits[1] : srcBits[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      bitCnt <= '0;
      opcode <= '0;
      address <= '0;
      dataValid <= 1'b0;
      dataByte <= '0;
    end else begin
      dataValid <= 1'b0;
      if (strobe.clrBits) begin
        bitCnt <= '0;
        shReg <= '0;
      end else if (strobe.shiftEn) begin
        shReg <= nextByte;
        bitCnt <= byteDone ? 4'd0 : stepSum;
      end
      if (strobe.loadOp && byteDone) opcode <= nextByte;
      if (strobe.clrAddr) address <= '0;
      else if (strobe.pushAddr && byteDone) address <= {address[ADDR_W-9:0], nextByte};
      if (strobe.dataEn && byteDone) begin
        dataValid <= 1'b1;
        dataByte <= nextByte;
      end
    end
  end
endmodule

// File: rtl/spi_dec_control.sv
module spi_dec_control
  import spi_dec_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sampleEdge,
  input  logic csFall,
  input  logic csRise,
  input  logic [3:0] bitCnt,
  input  opCfg_t lookCfg,
  output dpStrobe_t strobe,
  output opCfg_t frameCfg,
  output logic hdrValid,
  output logic endValid,
  output logic endDropped
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_LATCH, ST_ADDR, ST_DUMMY, ST_DATA
  } state_e;

  state_e state, stateNxt;
  logic [2:0] addrLeft;
  logic [DUMMY_W-1:0] dummyCnt;
  logic hdrSet, endSet, dropSet, lastBit;

  assign lastBit = (bitCnt + laneStep(strobe.lanes)) == 4'd8;

  always_comb begin
    strobe = '0;
    stateNxt = state;
    hdrSet = 1'b0;
    endSet = 1'b0;
    dropSet = 1'b0;
    if (state != ST_IDLE && csRise) begin
      stateNxt = ST_IDLE;
      endSet = 1'b1;
      dropSet = (state == ST_OPC);
    end else begin
      case (state)
        ST_IDLE: if (csFall) begin
          strobe.clrBits = 1'b1;
          strobe.clrAddr = 1'b1;
          stateNxt = ST_OPC;
        end
        ST_OPC: if (sampleEdge) begin
          strobe.shiftEn = 1'b1;
          strobe.loadOp = 1'b1;
          if (lastBit) stateNxt = ST_LATCH;
        end
        ST_LATCH: stateNxt = ST_ADDR;
        ST_ADDR: if (sampleEdge) begin
          strobe.shiftEn = 1'b1;
          strobe.pushAddr = 1'b1;
          if (lastBit && addrLeft == 3'd1) begin
            if (frameCfg.dummy == '0) begin
              hdrSet = 1'b1;
              stateNxt = ST_DATA;
            end else begin
              stateNxt = ST_DUMMY;
            end
          end
        end
        ST_DUMMY: if (sampleEdge && dummyCnt + 1'b1 == frameCfg.dummy) begin
          hdrSet = 1'b1;
          stateNxt = ST_DATA;
        end
        ST_DATA: if (sampleEdge) begin
          strobe.shiftEn = 1'b1;
          strobe.lanes = frameCfg.lanes;
          strobe.useDev = !frameCfg.isWrite;
          strobe.dataEn = 1'b1;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      addrLeft <= '0;
      dummyCnt <= '0;
      frameCfg <= '0;
      hdrValid <= 1'b0;
      endValid <= 1'b0;
      endDropped <= 1'b0;
    end else begin
      state <= stateNxt;
      hdrValid <= hdrSet;
      endValid <= endSet;
      endDropped <= dropSet;
      if (state == ST_LATCH) begin
        frameCfg <= lookCfg;
        addrLeft <= lookCfg.addr4 ? 3'd4 : 3'd3;
        dummyCnt <= '0;
      end else begin
        if (state == ST_ADDR && sampleEdge && lastBit && !csRise) addrLeft <= addrLeft - 1'b1;
        if (state == ST_DUMMY && sampleEdge && !csRise) dummyCnt <= dummyCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_decoder.sv
module spi_flash_decoder
  import spi_dec_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic clk,
  input  logic rstN,
  input  logic cpol,
  input  logic cpha,
  input  logic spiCsN,
  input  logic spiSck,
  input  logic [3:0] hostIo,
  input  logic [3:0] devIo,
  input  logic tblWe,
  input  logic [IDX_W-1:0] tblIdx,
  input  logic tblValid,
  input  logic [7:0] tblOpcode,
  input  logic tblAddr4,
  input  logic tblWrite,
  input  logic [1:0] tblLanes,
  input  logic [DUMMY_W-1:0] tblDummy,
  output logic hdrValid,
  output logic [7:0] hdrOpcode,
  output logic [ADDR_W-1:0] hdrAddr,
  output logic hdrWrite,
  output logic [1:0] hdrLanes,
  output logic [DUMMY_W-1:0] hdrDummy,
  output logic dataValid,
  output logic [7:0] dataByte,
  output logic endValid,
  output logic endDropped
);
  dpStrobe_t strobe;
  opCfg_t lookCfg, frameCfg, wrCfg;
  logic sampleEdge, csFall, csRise;
  logic [3:0] bitCnt;

  assign wrCfg = '{addr4: tblAddr4, isWrite: tblWrite, lanes: lanes_e'(tblLanes), dummy: tblDummy};

  spi_dec_optable #(.ENTRIES(ENTRIES)) uTable (
    .clk(clk), .rstN(rstN), .wrEn(tblWe), .wrIdx(tblIdx), .wrValid(tblValid),
    .wrOpcode(tblOpcode), .wrCfg(wrCfg), .lookOpcode(hdrOpcode), .lookCfg(lookCfg)
  );

  spi_dec_datapath uData (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .spiCsN(spiCsN), .spiSck(spiSck),
    .hostIo(hostIo), .devIo(devIo), .strobe(strobe), .sampleEdge(sampleEdge),
    .csFall(csFall), .csRise(csRise), .bitCnt(bitCnt), .opcode(hdrOpcode),
    .address(hdrAddr), .dataValid(dataValid), .dataByte(dataByte)
  );

  spi_dec_control uCtrl (
    .clk(clk), .rstN(rstN), .sampleEdge(sampleEdge), .csFall(csFall), .csRise(csRise),
    .bitCnt(bitCnt), .lookCfg(lookCfg), .strobe(strobe), .frameCfg(frameCfg),
    .hdrValid(hdrValid), .endValid(endValid), .endDropped(endDropped)
  );

  assign hdrWrite = frameCfg.isWrite;
  assign hdrLanes = frameCfg.lanes;
  assign hdrDummy = frameCfg.dummy;
endmodule

// File: rtl/spi_flash_decoder_chk.sv
module spi_flash_decoder_chk (
  input logic clk,
  input logic rstN,
  input logic hdrValid,
  input logic [1:0] hdrLanes,
  input logic dataValid,
  input logic endValid,
  input logic endDropped
);
  logic inHdr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inHdr <= 1'b0;
    else if (endValid) inHdr <= 1'b0;
    else if (hdrValid) inHdr <= 1'b1;
  end

  assert_hdr_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> !hdrValid);
  assert_data_after_hdr_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> inHdr);
  assert_drop_no_hdr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (endValid && endDropped) |-> !inHdr);
  assert_end_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    endValid |=> !endValid);
  assert_end_no_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    endValid |-> !dataValid);
  assert_lane_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> hdrLanes != 2'b11);
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!hdrValid && !dataValid && !endValid));
endmodule

bind spi_flash_decoder spi_flash_decoder_chk uChk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrLanes(hdrLanes),
  .dataValid(dataValid), .endValid(endValid), .endDropped(endDropped)
);

// File: tb/sim_spi_flash_decoder.sv
module sim_spi_flash_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, spiCsN = 1'b1, spiSck = 1'b0;
  logic [3:0] hostIo = '0, devIo = '0;
  logic tblWe = 1'b0, tblValid = 1'b0, tblAddr4 = 1'b0, tblWrite = 1'b0;
  logic [2:0] tblIdx = '0;
  logic [7:0] tblOpcode = '0;
  logic [1:0] tblLanes = '0;
  logic [4:0] tblDummy = '0;
  logic hdrValid, hdrWrite, dataValid, endValid, endDropped;
  logic [7:0] hdrOpcode, dataByte;
  logic [31:0] hdrAddr;
  logic [1:0] hdrLanes;
  logic [4:0] hdrDummy;

  always #2.5 clk = ~clk;

  spi_flash_decoder u0 (.*);

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  localparam int HALF = 4;

  // model table
  bit mValid [8];
  logic [7:0] mOp [8];
  bit mA4 [8], mWr [8];
  int mLanes [8], mDum [8];

  // monitor records
  int nHdr, nData, nEnd, dataEarly;
  logic [7:0] gOp, gData [16];
  logic [31:0] gAddr;
  logic gWr, gDrop;
  logic [1:0] gLanes;
  logic [4:0] gDum;

  always @(negedge clk) begin
    if (hdrValid) begin
      nHdr++; gOp = hdrOpcode; gAddr = hdrAddr; gWr = hdrWrite; gLanes = hdrLanes; gDum = hdrDummy;
    end
    if (dataValid) begin
      if (nHdr == 0) dataEarly++;
      if (nData < 16) gData[nData] = dataByte;
      nData++;
    end
    if (endValid) begin nEnd++; gDrop = endDropped; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tblWr(input int idx, input bit v, input logic [7:0] op, input bit a4,
                       input bit wr, input int lanes, input int dum);
    @(negedge clk);
    tblWe = 1; tblIdx = 3'(idx); tblValid = v; tblOpcode = op; tblAddr4 = a4;
    tblWrite = wr; tblLanes = 2'(lanes); tblDummy = 5'(dum);
    @(negedge clk);
    tblWe = 0;
    mValid[idx] = v; mOp[idx] = op; mA4[idx] = a4; mWr[idx] = wr;
    mLanes[idx] = (lanes == 3) ? 0 : lanes; mDum[idx] = dum;
  endtask

  function automatic void lookup(input logic [7:0] op, output bit a4, output bit wr,
                                 output int lanes, output int dum);
    a4 = 0; wr = 0; lanes = 0; dum = 0;
    for (int i = 7; i >= 0; i--)
      if (mValid[i] && mOp[i] == op) begin a4 = mA4[i]; wr = mWr[i]; lanes = mLanes[i]; dum = mDum[i]; end
  endfunction

  // one sampled bit-group (R10: leading edge with cpha=1 carries nothing)
  task automatic edgeOut(input logic [3:0] h, input logic [3:0] d);
    if (!cpha) begin
      hostIo = h; devIo = d; clks(HALF);
      spiSck = ~cpol; clks(HALF);
      spiSck = cpol;
    end else begin
      spiSck = ~cpol; hostIo = h; devIo = d; clks(HALF);
      spiSck = cpol; clks(HALF);
    end
  endtask

  task automatic sendHostByte(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--) begin
      logic [3:0] h;
      h = 4'($urandom); h[0] = b[i];
      edgeOut(h, 4'($urandom));
    end
  endtask

  task automatic sendPayload(input logic [7:0] b, input int lanes, input bit wr);
    int step;
    step = (lanes == 2) ? 4 : (lanes == 1) ? 2 : 1;
    for (int i = 8 - step; i >= 0; i -= step) begin
      logic [3:0] h, d, v;
      h = 4'($urandom); d = 4'($urandom);
      v = 4'(b >> i);
      if (step == 1) begin if (wr) h[0] = v[0]; else d[1] = v[0]; end
      else if (step == 2) begin if (wr) h[1:0] = v[1:0]; else d[1:0] = v[1:0]; end
      else begin if (wr) h = v; else d = v; end
      edgeOut(h, d);
    end
  endtask

  // cutOp < 8: abort inside opcode; cutAddr >= 0: abort after that many address bytes
  task automatic frame(input int mode, input logic [7:0] op, input logic [31:0] addr,
                       input int nPay, input int partEdges, input int cutOp, input int cutAddr);
    bit a4, wr; int lanes, dum, nA; logic [7:0] pay [8]; logic [31:0] expAddr;
    cpol = mode[1]; cpha = mode[0]; spiSck = cpol;
    lookup(op, a4, wr, lanes, dum);
    nA = a4 ? 4 : 3;
    expAddr = a4 ? addr : {8'h00, addr[23:0]};
    nHdr = 0; nData = 0; nEnd = 0; dataEarly = 0;
    clks(4);
    spiCsN = 0; clks(HALF);
    sendHostByte(op, (cutOp < 8) ? cutOp : 8);
    if (cutOp >= 8) begin
      for (int k = nA - 1; k >= 0; k--)
        if (cutAddr < 0 || (nA - 1 - k) < cutAddr) sendHostByte(addr[8*k +: 8], 8);
      if (cutAddr < 0) begin
        repeat (dum) edgeOut(4'($urandom), 4'($urandom));
        for (int p = 0; p < nPay; p++) begin
          pay[p] = 8'($urandom);
          sendPayload(pay[p], lanes, wr);
        end
        repeat (partEdges) edgeOut(4'($urandom), 4'($urandom));
      end
    end
    clks(HALF); spiCsN = 1; clks(6);
    chk("R9 end count", nEnd, 1);
    if (cutOp < 8) begin
      chk("R9 dropped flag", gDrop, 1);
      chk("R9 no header on drop", nHdr, 0);
      chk("R8 no data on drop", nData, 0);
    end else if (cutAddr >= 0) begin
      chk("R9 not dropped", gDrop, 0);
      chk("R4 no header on short address", nHdr, 0);
    end else begin
      chk("R9 not dropped", gDrop, 0);
      chk("R6 header count", nHdr, 1);
      chk("R6 header before data", dataEarly, 0);
      chk("R1 opcode", gOp, op);
      chk("R4 address", gAddr, expAddr);
      chk("R2 R3 write flag", gWr, wr);
      chk("R2 R3 lanes", gLanes, lanes);
      chk("R5 dummy", gDum, dum);
      chk("R8 byte count", nData, nPay);
      for (int p = 0; p < nPay && p < nData; p++) chk("R7 R10 payload", gData[p], pay[p]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++; nCmp++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [10];
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 8; i++) mValid[i] = 0;
    clks(3);
    chk("R11 hdr in reset", hdrValid, 0);
    chk("R11 data in reset", dataValid, 0);
    chk("R11 end in reset", endValid, 0);
    rstN = 1; clks(2);
    chk("R11 end after reset", {hdrValid, dataValid, endValid}, 0);

    tblWr(0, 1, 8'h0B, 0, 0, 0, 8);
    tblWr(1, 1, 8'h3B, 0, 0, 1, 8);
    tblWr(2, 1, 8'h6B, 1, 0, 2, 8);
    tblWr(3, 1, 8'h02, 0, 1, 0, 0);
    tblWr(4, 1, 8'h32, 1, 1, 2, 0);
    tblWr(5, 1, 8'hEB, 1, 0, 2, 6);
    tblWr(6, 1, 8'h0B, 1, 1, 2, 2);   // R2 duplicate, lower index wins
    tblWr(7, 0, 8'h99, 1, 1, 1, 3);   // R2 invalid entry, R3 default
    ops = '{8'h0B, 8'h3B, 8'h6B, 8'h02, 8'h32, 8'hEB, 8'h99, 8'h55, 8'h3B, 8'h32};

    for (int m = 0; m < 4; m++) frame(m, 8'h0B, 32'h00A1B2C3, 3, 0, 8, -1); // R10 modes
    frame(0, 8'h99, 32'h12345678, 2, 3, 8, -1);   // R3
    frame(3, 8'h55, 32'h00FFEEDD, 0, 0, 8, -1);   // R3 no payload
    frame(1, 8'hEB, 32'hDEADBEEF, 4, 1, 8, -1);   // R7 quad read
    frame(2, 8'h32, 32'hCAFEF00D, 3, 0, 8, -1);   // R7 quad write, dummy 0
    frame(0, 8'h02, 32'h00010203, 2, 7, 8, -1);   // R8 partial byte
    frame(1, 8'h3B, 32'h00445566, 2, 3, 8, -1);   // R7 dual partial
    frame(0, 8'hA5, 32'h0, 0, 0, 5, -1);          // R9 dropped
    frame(3, 8'hA5, 32'h0, 0, 0, 0, -1);          // R9 dropped at zero bits
    frame(2, 8'h6B, 32'h11223344, 0, 0, 8, 2);    // R4 cut in address

    for (int r = 0; r < 30; r++) begin
      int sel, lanesSteps;
      bit a4, wr; int lanes, dum;
      sel = $urandom_range(0, 9);
      lookup(ops[sel], a4, wr, lanes, dum);
      lanesSteps = (lanes == 2) ? 2 : (lanes == 1) ? 4 : 8;
      frame($urandom_range(0, 3), ops[sel], $urandom, $urandom_range(0, 4),
            $urandom_range(0, lanesSteps - 1), 8, -1);
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule